// File: doc/BRIEF.md
# Half-Bridge Switch Guard

This block sits between the control registers of a three-leg half-bridge driver and its six gate drivers. Each leg has one high-side and one low-side switch. The block turns per-switch enable bits into gate-enable outputs. Any switch can be routed through one shared PWM pin. A single run bit can force every switch off at once. The block never lets both switches of one leg conduct together.

The block also owns the fault policy. Analog comparators outside the block deliver digital flags:

- Per leg: a thermal trip flag, a "cooled below switch-on level" flag, and a prewarning pair with a set level and a reset level.
- Per switch: an overcurrent flag.

Thermal trips and armed overcurrent events latch switches off and raise a shared overload flag. A latched switch comes back only when its fault has gone away and a one-cycle clear request arrives. Overcurrent must persist for a parameterised number of cycles before it latches. The prewarning output follows a two-level hysteresis.

Top module: `hb_guard`

## Requirements
- R1: One clock after the inputs are applied, with the run bit high and no latched fault, each high-side gate equals its enable bit. If the switch's PWM-select bit is 1, the enable is ANDed with the shared PWM pin. The low side follows the same rule with its own enable and select bits. Bit i of every per-leg or per-switch vector belongs to leg i.
- R2: If, after PWM gating, both switches of a leg are requested in the same cycle, both gates of that leg are driven 0. No leg ever has both gates at 1.
- R3: While the run bit is 0, every gate is 0 one clock later. The run bit does not change the status bits or the overload flag.
- R4: A thermal trip flag on leg i clears both status bits of leg i and both its gates one clock later, and sets the overload flag.
- R5: A thermally latched leg is released only by a clear-request pulse in a cycle where its cooled flag is 1. A clear request while the leg is not cooled releases nothing.
- R6: With overcurrent shutdown armed, an overcurrent flag held for OC_DELAY consecutive clock edges latches that switch off on the OC_DELAY-th edge. That switch's status and gate go to 0, and the overload flag goes to 1.
- R7: An overcurrent flag that drops before OC_DELAY edges restarts the count, so a later run of fewer than OC_DELAY edges also does not latch.
- R8: With overcurrent shutdown disarmed, an overcurrent flag never latches a switch and never sets the overload flag.
- R9: A clear-request pulse releases an overcurrent latch only if that switch's overcurrent flag is 0 in that cycle. The overload flag is 1 exactly when at least one latch is held after the clock edge.
- R10: The prewarning flag is set one clock after any leg's set-level flag is 1. It returns to 0 only in a cycle where no set-level flag is 1 and every leg's reset-level flag is 1 (reset-level flag 1 means the leg is below the reset level). Otherwise it holds its value.
- R11: During and after reset, before any stimulus: all gates are 0, all status bits are 1, and the overload and prewarning flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 = normal control, 0 = all gates off |
| hs_en | input | NB | High-side enable per leg |
| ls_en | input | NB | Low-side enable per leg |
| hs_pwm_sel | input | NB | High-side switch gated by PWM pin |
| ls_pwm_sel | input | NB | Low-side switch gated by PWM pin |
| pwm_in | input | 1 | Shared PWM pin |
| oc_arm | input | 1 | Arms overcurrent shutdown |
| clr_req | input | 1 | One-cycle clear request for latched faults |
| oc_hs | input | NB | High-side overcurrent flag per leg |
| oc_ls | input | NB | Low-side overcurrent flag per leg |
| th_trip | input | NB | Leg above thermal shutdown level |
| th_cool | input | NB | Leg below thermal switch-on level |
| pw_hi | input | NB | Leg above prewarning set level |
| pw_lo | input | NB | Leg below prewarning reset level |
| hs_gate | output | NB | High-side gate enable |
| ls_gate | output | NB | Low-side gate enable |
| hs_ok | output | NB | High-side not fault-disabled |
| ls_ok | output | NB | Low-side not fault-disabled |
| ovl | output | 1 | Overload flag |
| tp | output | 1 | Thermal prewarning flag |

## Verification
The bench builds the block with NB = 3 and OC_DELAY = 4. These values make every leg index, including the top bit, reachable within a few cycles.

With a four-edge shutdown window, three runs fit in a short test: a run that latches exactly on the fourth edge, a three-edge glitch that does not latch, and a glitch followed by a restart. Boundary counts on both sides of the window are therefore checked directly.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Gate request for one switch after optional PWM gating.
  function automatic logic pwm_gate(input logic en, input logic sel, input logic pwm);
    return en & (~sel | pwm);
  endfunction

  typedef struct packed {
    logic hs;
    logic ls;
  } leg_req_t;

endpackage

// File: rtl/hb_oc_timer.sv
module hb_oc_timer #(
  parameter int OC_DELAY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic oc,
  output logic fire
);
  localparam int CW   = (OC_DELAY > 1) ? $clog2(OC_DELAY) : 1;
  localparam int LAST = OC_DELAY - 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == CW'(LAST));
  assign fire    = arm & oc & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (!(arm && oc)) begin
      cnt_d = '0;
    end else if (!at_last) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/hb_fault_core.sv
module hb_fault_core #(
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_req,
  input  logic [NB-1:0] th_trip,
  input  logic [NB-1:0] th_cool,
  input  logic [NB-1:0] oc_hs,
  input  logic [NB-1:0] oc_ls,
  input  logic [NB-1:0] fire_hs,
  input  logic [NB-1:0] fire_ls,
  output logic [NB-1:0] dis_hs_d,
  output logic [NB-1:0] dis_ls_d,
  output logic [NB-1:0] hs_ok,
  output logic [NB-1:0] ls_ok,
  output logic          ovl
);
  logic [NB-1:0] th_lat_q, th_lat_d;
  logic [NB-1:0] ochs_q, ochs_d;
  logic [NB-1:0] ocls_q, ocls_d;
  logic          ovl_d;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      th_lat_d[i] = th_trip[i] | (th_lat_q[i] & ~(clr_req & th_cool[i]));
      ochs_d[i]   = fire_hs[i] | (ochs_q[i] & ~(clr_req & ~oc_hs[i]));
      ocls_d[i]   = fire_ls[i] | (ocls_q[i] & ~(clr_req & ~oc_ls[i]));
    end
    dis_hs_d = th_lat_d | ochs_d;
    dis_ls_d = th_lat_d | ocls_d;
    ovl_d    = |{th_lat_d, ochs_d, ocls_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      th_lat_q <= '0;
      ochs_q   <= '0;
      ocls_q   <= '0;
      hs_ok    <= '1;
      ls_ok    <= '1;
      ovl      <= 1'b0;
    end else begin
      th_lat_q <= th_lat_d;
      ochs_q   <= ochs_d;
      ocls_q   <= ocls_d;
      hs_ok    <= ~dis_hs_d;
      ls_ok    <= ~dis_ls_d;
      ovl      <= ovl_d;
    end
  end

endmodule

// File: rtl/hb_gate_stage.sv
module hb_gate_stage
  import hb_pkg::*;
#(
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          pwm_in,
  input  logic [NB-1:0] hs_en,
  input  logic [NB-1:0] ls_en,
  input  logic [NB-1:0] hs_pwm_sel,
  input  logic [NB-1:0] ls_pwm_sel,
  input  logic [NB-1:0] dis_hs_d,
  input  logic [NB-1:0] dis_ls_d,
  output logic [NB-1:0] hs_gate,
  output logic [NB-1:0] ls_gate
);
  leg_req_t      req [NB];
  logic [NB-1:0] hs_d, ls_d;

  for (genvar i = 0; i < NB; i++) begin : g_leg
    logic both;
    assign req[i].hs = pwm_gate(hs_en[i], hs_pwm_sel[i], pwm_in);
    assign req[i].ls = pwm_gate(ls_en[i], ls_pwm_sel[i], pwm_in);
    assign both      = req[i].hs & req[i].ls;
    assign hs_d[i]   = run & ~both & req[i].hs & ~dis_hs_d[i];
    assign ls_d[i]   = run & ~both & req[i].ls & ~dis_ls_d[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_gate <= '0;
      ls_gate <= '0;
    end else begin
      hs_gate <= hs_d;
      ls_gate <= ls_d;
    end
  end

endmodule

// File: rtl/hb_prewarn.sv
module hb_prewarn #(
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] pw_hi,
  input  logic [NB-1:0] pw_lo,
  output logic          tp
);
  logic tp_d;

  always_comb begin
    tp_d = tp;
    if (|pw_hi)      tp_d = 1'b1;
    else if (&pw_lo) tp_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tp <= 1'b0;
    else        tp <= tp_d;
  end

endmodule

// File: rtl/hb_guard.sv
module hb_guard #(
  parameter int NB       = 3,
  parameter int OC_DELAY = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [NB-1:0] hs_en,
  input  logic [NB-1:0] ls_en,
  input  logic [NB-1:0] hs_pwm_sel,
  input  logic [NB-1:0] ls_pwm_sel,
  input  logic          pwm_in,
  input  logic          oc_arm,
  input  logic          clr_req,
  input  logic [NB-1:0] oc_hs,
  input  logic [NB-1:0] oc_ls,
  input  logic [NB-1:0] th_trip,
  input  logic [NB-1:0] th_cool,
  input  logic [NB-1:0] pw_hi,
  input  logic [NB-1:0] pw_lo,
  output logic [NB-1:0] hs_gate,
  output logic [NB-1:0] ls_gate,
  output logic [NB-1:0] hs_ok,
  output logic [NB-1:0] ls_ok,
  output logic          ovl,
  output logic          tp
);
  logic [NB-1:0] fire_hs, fire_ls;
  logic [NB-1:0] dis_hs_d, dis_ls_d;

  for (genvar i = 0; i < NB; i++) begin : g_oc
    hb_oc_timer #(.OC_DELAY(OC_DELAY)) u_hs (
      .clk(clk), .rst_n(rst_n), .arm(oc_arm), .oc(oc_hs[i]), .fire(fire_hs[i])
    );
    hb_oc_timer #(.OC_DELAY(OC_DELAY)) u_ls (
      .clk(clk), .rst_n(rst_n), .arm(oc_arm), .oc(oc_ls[i]), .fire(fire_ls[i])
    );
  end

  hb_fault_core #(.NB(NB)) u_fault (
    .clk(clk), .rst_n(rst_n), .clr_req(clr_req),
    .th_trip(th_trip), .th_cool(th_cool),
    .oc_hs(oc_hs), .oc_ls(oc_ls),
    .fire_hs(fire_hs), .fire_ls(fire_ls),
    .dis_hs_d(dis_hs_d), .dis_ls_d(dis_ls_d),
    .hs_ok(hs_ok), .ls_ok(ls_ok), .ovl(ovl)
  );

  hb_gate_stage #(.NB(NB)) u_gate (
    .clk(clk), .rst_n(rst_n), .run(run), .pwm_in(pwm_in),
    .hs_en(hs_en), .ls_en(ls_en),
    .hs_pwm_sel(hs_pwm_sel), .ls_pwm_sel(ls_pwm_sel),
    .dis_hs_d(dis_hs_d), .dis_ls_d(dis_ls_d),
    .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  hb_prewarn #(.NB(NB)) u_pw (
    .clk(clk), .rst_n(rst_n), .pw_hi(pw_hi), .pw_lo(pw_lo), .tp(tp)
  );

endmodule

// File: rtl/hb_guard_chk.sv
module hb_guard_chk #(
  parameter int NB = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          oc_arm,
  input logic          clr_req,
  input logic [NB-1:0] th_trip,
  input logic [NB-1:0] pw_hi,
  input logic [NB-1:0] hs_gate,
  input logic [NB-1:0] ls_gate,
  input logic [NB-1:0] hs_ok,
  input logic [NB-1:0] ls_ok,
  input logic          ovl,
  input logic          tp
);

  assert_no_shoot_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate & ls_gate) == '0);

  assert_run_low_gates_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hs_gate == '0 && ls_gate == '0));

  assert_trip_sets_ovl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    th_trip != '0 |=> ovl);

  assert_disarmed_no_ovl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_arm && th_trip == '0 && !ovl) |=> !ovl);

  assert_release_needs_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (((hs_ok & ~$past(hs_ok)) | (ls_ok & ~$past(ls_ok))) != '0) |-> $past(clr_req));

  assert_prewarn_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pw_hi != '0 |=> tp);

endmodule

bind hb_guard hb_guard_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .oc_arm(oc_arm), .clr_req(clr_req),
  .th_trip(th_trip), .pw_hi(pw_hi),
  .hs_gate(hs_gate), .ls_gate(ls_gate), .hs_ok(hs_ok), .ls_ok(ls_ok),
  .ovl(ovl), .tp(tp)
);

// File: tb/sim_hb_guard.sv
module sim_hb_guard;
  localparam int NB = 3;
  localparam int OCD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run, pwm_in, oc_arm, clr_req;
  logic [NB-1:0] hs_en, ls_en, hs_pwm_sel, ls_pwm_sel;
  logic [NB-1:0] oc_hs, oc_ls, th_trip, th_cool, pw_hi, pw_lo;
  logic [NB-1:0] hs_gate, ls_gate, hs_ok, ls_ok;
  logic ovl, tp;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hb_guard #(.NB(NB), .OC_DELAY(OCD)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run),
    .hs_en(hs_en), .ls_en(ls_en), .hs_pwm_sel(hs_pwm_sel), .ls_pwm_sel(ls_pwm_sel),
    .pwm_in(pwm_in), .oc_arm(oc_arm), .clr_req(clr_req),
    .oc_hs(oc_hs), .oc_ls(oc_ls), .th_trip(th_trip), .th_cool(th_cool),
    .pw_hi(pw_hi), .pw_lo(pw_lo),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .hs_ok(hs_ok), .ls_ok(ls_ok),
    .ovl(ovl), .tp(tp)
  );

  // {hs_en, ls_en, hs_sel, ls_sel, pwm, exp_hs, exp_ls}
  localparam logic [18:0] VEC [8] = '{
    {3'b001, 3'b010, 3'b000, 3'b000, 1'b0, 3'b001, 3'b010},
    {3'b001, 3'b010, 3'b001, 3'b000, 1'b0, 3'b000, 3'b010},
    {3'b001, 3'b010, 3'b001, 3'b000, 1'b1, 3'b001, 3'b010},
    {3'b111, 3'b000, 3'b101, 3'b000, 1'b0, 3'b010, 3'b000},
    {3'b111, 3'b000, 3'b101, 3'b000, 1'b1, 3'b111, 3'b000},
    {3'b100, 3'b100, 3'b000, 3'b000, 1'b0, 3'b000, 3'b000},
    {3'b100, 3'b100, 3'b100, 3'b000, 1'b0, 3'b000, 3'b100},
    {3'b000, 3'b111, 3'b000, 3'b011, 1'b0, 3'b000, 3'b100}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_clear();
    clr_req = 1'b1;
    step(1);
    clr_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #40000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    run = 1'b1; pwm_in = 1'b0; oc_arm = 1'b0; clr_req = 1'b0;
    hs_en = '0; ls_en = '0; hs_pwm_sel = '0; ls_pwm_sel = '0;
    oc_hs = '0; oc_ls = '0; th_trip = '0; th_cool = '1; pw_hi = '0; pw_lo = '1;
    step(3);
    // R11 reset state
    check("R11 gates", {2'b0, hs_gate, ls_gate}, 8'h00);
    check("R11 status", {2'b0, hs_ok, ls_ok}, 8'h3f);
    check("R11 flags", {6'b0, ovl, tp}, 8'h00);
    rst_n = 1'b1;
    step(2);
    check("R11 after release", {2'b0, hs_ok, ls_ok}, 8'h3f);

    // R1 / R2 table
    for (int v = 0; v < 8; v++) begin
      {hs_en, ls_en, hs_pwm_sel, ls_pwm_sel, pwm_in} = VEC[v][18:6];
      step(1);
      check((v >= 5) ? "R2 table" : "R1 table",
            {2'b0, hs_gate, ls_gate}, {2'b0, VEC[v][5:0]});
    end

    // R3 run low
    hs_en = 3'b011; ls_en = 3'b100; hs_pwm_sel = '0; ls_pwm_sel = '0;
    run = 1'b0;
    step(1);
    check("R3 gates off", {2'b0, hs_gate, ls_gate}, 8'h00);
    check("R3 status kept", {1'b0, ovl, hs_ok, ls_ok}, 8'h3f);
    run = 1'b1;
    step(1);
    check("R3 restored", {2'b0, hs_gate, ls_gate}, {2'b0, 3'b011, 3'b100});

    // R4 thermal trip on leg 2
    th_trip = 3'b100; th_cool = 3'b011;
    step(1);
    check("R4 status", {2'b0, hs_ok, ls_ok}, {2'b0, 3'b011, 3'b011});
    check("R4 gates", {2'b0, hs_gate, ls_gate}, {2'b0, 3'b011, 3'b000});
    check("R4 ovl", {7'b0, ovl}, 8'h01);
    // R5 clear while not cooled
    th_trip = 3'b000;
    pulse_clear();
    check("R5 not cooled", {1'b0, ovl, hs_ok, ls_ok}, {2'b01, 3'b011, 3'b011});
    th_cool = 3'b111;
    step(2);
    check("R5 no clear no release", {1'b0, ovl, hs_ok, ls_ok}, {2'b01, 3'b011, 3'b011});
    pulse_clear();
    check("R5 released", {1'b0, ovl, hs_ok, ls_ok}, 8'h3f);
    step(1);
    check("R5 gates back", {2'b0, hs_gate, ls_gate}, {2'b0, 3'b011, 3'b100});

    // R8 disarmed overcurrent
    oc_hs = 3'b001;
    step(OCD + 3);
    check("R8 disarmed", {1'b0, ovl, hs_ok, ls_ok}, 8'h3f);
    oc_hs = '0;
    step(1);

    // R7 glitch shorter than window, then restart
    oc_arm = 1'b1;
    oc_hs = 3'b001;
    step(OCD - 1);
    oc_hs = '0;
    step(1);
    oc_hs = 3'b001;
    step(OCD - 1);
    check("R7 glitch no latch", {1'b0, ovl, hs_ok, ls_ok}, 8'h3f);
    // R6: one more edge completes a full window
    step(1);
    check("R6 latched status", {2'b0, hs_ok, ls_ok}, {2'b0, 3'b110, 3'b111});
    check("R6 ovl", {7'b0, ovl}, 8'h01);
    step(1);
    check("R6 gate off", {2'b0, hs_gate, ls_gate}, {2'b0, 3'b010, 3'b100});
    // R9 clear while overcurrent present does nothing
    pulse_clear();
    check("R9 clear blocked", {1'b0, ovl, hs_ok, ls_ok}, {2'b01, 3'b110, 3'b111});
    oc_hs = '0;
    step(1);
    check("R9 held w/o clear", {1'b0, ovl, hs_ok, ls_ok}, {2'b01, 3'b110, 3'b111});
    pulse_clear();
    check("R9 released", {1'b0, ovl, hs_ok, ls_ok}, 8'h3f);
    // R6 low-side top leg, exact window
    ls_en = 3'b000;
    oc_ls = 3'b100;
    step(OCD);
    check("R6 low side", {1'b0, ovl, hs_ok, ls_ok}, {2'b01, 3'b111, 3'b011});
    oc_ls = '0;
    oc_arm = 1'b0;
    pulse_clear();
    check("R9 ovl cleared", {7'b0, ovl}, 8'h00);

    // R10 prewarning hysteresis
    pw_hi = 3'b010; pw_lo = 3'b101;
    step(1);
    check("R10 set", {7'b0, tp}, 8'h01);
    pw_hi = 3'b000;
    step(2);
    check("R10 hold", {7'b0, tp}, 8'h01);
    pw_lo = 3'b111;
    step(1);
    check("R10 cleared", {7'b0, tp}, 8'h00);
    pw_lo = 3'b011;
    step(1);
    check("R10 stays low", {7'b0, tp}, 8'h00);

    finish_run();
  end

endmodule